// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control for an 8-bit successive-approximation converter that sits behind a small register interface. A bus master writes a control register to choose the channel, the ADC clock rate and single or continuous mode. Each such write requests a conversion. The block divides the bus clock into an ADC clock-enable. It drives a sample strobe and a trial code to the analog front end, and it turns the front end's comparator answers into an 8-bit result.

Every conversion lasts twelve ADC clock periods. The first period samples the input. The next eight resolve one result bit each, most significant bit first. The last three are transfer and settle time, and the result register is loaded at the end of the twelfth period. A completion flag in the status register reports each new result. A control write clears the flag, and so does a read of the result register.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the result register reads 0x00, and `sample` is low.
- R2: `adc_clk_en` is high for one bus cycle in every 2^d bus cycles, where d is the divider code. Codes above 4 act as 4.
- R3: A conversion starts on the first `adc_clk_en` edge strictly after the edge that takes a control write. `sample` is high during the first ADC period of every conversion.
- R4: The completion flag and the result are updated at the 12th `adc_clk_en` edge after the start edge, and not before.
- R5: `cmp_hi` = 1 means the input is at or above `trial`. The result is the largest code whose trial compared high, resolved MSB first. Input at or above full scale gives 0xFF, and input at or below zero gives 0x00.
- R6: In single mode the block goes idle after one conversion. No further result or flag appears until the next control write.
- R7: In continuous mode a new conversion starts at the same edge that completes the previous one. Each result overwrites the result register and sets the flag, whether or not the previous result was read.
- R8: A control write clears the completion flag.
- R9: A read of the result register (`rd_en`=1, `addr`=1) clears the completion flag.
- R10: If a result read and a completion fall on the same edge, the flag stays set and the new result is loaded.
- R11: A control write during a conversion aborts it. The new channel shows on `chan` at once, the aborted conversion never completes, and a new conversion starts per R3.
- R12: Status register layout: bit 7 is the completion flag (read-only), bit 6 is continuous mode, bits 5:3 are the divider code, and bits 2:0 are the channel. `addr`=0 selects the status register and `addr`=1 the result register. `rdata` follows `addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 1 | 0 = status/control, 1 = result |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| adc_clk_en | output | 1 | ADC clock-enable pulse |
| sample | output | 1 | Front-end sample strobe |
| trial | output | 8 | Trial code presented to the comparator |
| cmp_hi | input | 1 | Comparator answer: input is at or above trial |
| chan | output | 3 | Selected analog channel |
| conv_busy | output | 1 | A conversion is in progress |

## Verification
The assertions assume `wr_en` targets only `addr`=0. They also assume `cmp_hi` is settled before each `adc_clk_en` edge, since the block latches it only on those edges. The bench meets both conditions. It changes the modelled input only at falling edges, and never inside a resolve period of a conversion whose result it checks. It derives `cmp_hi` combinationally from an ideal integer input compared with `trial`.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int DIV_MAX = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       adc_clk_en,
  output logic       sample,
  output logic [7:0] trial,
  input  logic       cmp_hi,
  output logic [2:0] chan,
  output logic       conv_busy
);
  localparam int CNT_W = DIV_MAX;
  localparam logic [3:0] LAST_STEP = 4'd12;

  logic [2:0] div_q, chan_q;
  logic cont_q, done_q, pend_q, busy_q;
  logic [3:0] step_q;
  logic [7:0] sar_q, probe_q, data_q;
  logic [CNT_W-1:0] cnt_q, limit;
  logic [CNT_W:0] span;
  logic [2:0] div_eff;

  wire ctrl_wr = wr_en && !addr;
  wire data_rd = rd_en && addr;

  assign div_eff = (div_q > 3'(DIV_MAX)) ? 3'(DIV_MAX) : div_q;
  always_comb begin
    span  = (CNT_W+1)'(1) << div_eff;
    limit = CNT_W'(span - 1'b1);
  end

  wire tick = cnt_q >= limit;
  wire fin  = !ctrl_wr && busy_q && tick && step_q == LAST_STEP;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= tick ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q <= 1'b0; div_q <= '0; chan_q <= '0;
      pend_q <= 1'b0; busy_q <= 1'b0; step_q <= '0;
      sar_q <= '0; probe_q <= '0;
    end else if (ctrl_wr) begin
      cont_q <= wdata[6]; div_q <= wdata[5:3]; chan_q <= wdata[2:0];
      pend_q <= 1'b1; busy_q <= 1'b0; step_q <= '0;
      sar_q <= '0; probe_q <= '0;
    end else if (tick) begin
      if (pend_q) begin
        pend_q <= 1'b0; busy_q <= 1'b1; step_q <= 4'd1;
        sar_q <= '0; probe_q <= '0;
      end else if (busy_q) begin
        if (step_q == LAST_STEP) begin
          busy_q <= cont_q;
          step_q <= cont_q ? 4'd1 : 4'd0;
          sar_q <= '0; probe_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
          if (step_q == 4'd1) probe_q <= 8'h80;
          else if (probe_q != '0) begin
            if (cmp_hi) sar_q <= sar_q | probe_q;
            probe_q <= probe_q >> 1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; data_q <= '0;
    end else begin
      if (fin) data_q <= sar_q;
      if (ctrl_wr)      done_q <= 1'b0;
      else if (fin)     done_q <= 1'b1;
      else if (data_rd) done_q <= 1'b0;
    end
  end

  assign adc_clk_en = tick;
  assign sample     = busy_q && step_q == 4'd1;
  assign trial      = sar_q | probe_q;
  assign chan       = chan_q;
  assign conv_busy  = busy_q;
  assign rdata      = addr ? data_q : {done_q, cont_q, div_q, chan_q};
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic       adc_clk_en,
  input logic       sample,
  input logic       done,
  input logic [7:0] data
);
  assert_done_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(adc_clk_en));
  assert_sample_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample) |-> $past(adc_clk_en));
  assert_wr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr) |=> !done);
  assert_rd_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr && !wr_en && !adc_clk_en) |=> !done);
  assert_data_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data) |-> done);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk, .rst_n, .wr_en, .rd_en, .addr, .adc_clk_en, .sample,
  .done(done_q), .data(data_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, addr = 0;
  logic [7:0] wdata = 0, rdata, trial;
  logic adc_clk_en, sample, cmp_hi, conv_busy;
  logic [2:0] chan;
  int vin = 0;
  int checks = 0, errors = 0;

  localparam int NV = 9;
  localparam int VIN [NV] = '{-20, 0, 1, 127, 128, 200, 254, 255, 300};
  localparam int EXP [NV] = '{0, 0, 1, 127, 128, 200, 254, 255, 255};

  always #5 clk = ~clk;
  assign cmp_hi = (vin >= int'(trial));

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wdata, .rdata, .adc_clk_en,
    .sample, .trial, .cmp_hi, .chan, .conv_busy
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input bit cont, input int div, input int ch);
    @(negedge clk);
    addr = 0; wr_en = 1; wdata = {1'b0, cont, 3'(div), 3'(ch)};
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic peek_done();
    return i_adc_seq_ctrl.rdata[7] & ~addr | (addr & 1'b0);
  endfunction

  task automatic status(output logic [7:0] s);
    addr = 0; #1; s = rdata;
  endtask

  task automatic data_peek(output logic [7:0] d);
    addr = 1; #1; d = rdata; addr = 0;
  endtask

  task automatic wait_done(input string req);
    logic [7:0] s;
    for (int k = 0; k < 3000; k++) begin
      status(s);
      if (s[7]) return;
      @(negedge clk);
    end
    check(0, req, 0, 1);
  endtask

  task automatic rd_data(output logic [7:0] d);
    @(negedge clk);
    addr = 1; rd_en = 1; #1; d = rdata;
    @(negedge clk);
    rd_en = 0; addr = 0;
  endtask

  // counts ADC edges after a write; returns at the falling edge before the 13th
  task automatic run_to_end(output bit early, output bit smp);
    logic [7:0] s;
    int n = 0;
    early = 0; smp = 0;
    for (int k = 0; k < 400; k++) begin
      if (adc_clk_en) begin
        n++;
        if (n == 13) return;
      end
      @(negedge clk);
      status(s);
      if (s[7]) early = 1;
      if (n == 1 && sample) smp = 1;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    bit early, smp;
    int gap, p1;
    repeat (3) @(negedge clk);
    status(s);
    check(s == 8'h00, "R1 status", s, 0);
    data_peek(d);
    check(d == 8'h00, "R1 data", d, 0);
    check(sample == 0, "R1 sample", sample, 0);
    rst_n = 1;

    // R2: divider periods
    foreach (VIN[i]) begin end
    for (int t = 0; t < 3; t++) begin
      int code = (t == 0) ? 0 : (t == 1) ? 3 : 7;
      int expg = (t == 0) ? 1 : (t == 1) ? 8 : 16;
      wr_ctrl(0, code, 0);
      while (!adc_clk_en) @(negedge clk);
      @(negedge clk);
      gap = 1;
      while (!adc_clk_en) begin gap++; @(negedge clk); end
      check(gap == expg, "R2 divider period", gap, expg);
    end

    // R5: table of inputs through single conversions
    for (int i = 0; i < NV; i++) begin
      vin = VIN[i];
      wr_ctrl(0, 0, i % 8);
      check(chan == 3'(i % 8), "R12 chan out", chan, i % 8);
      wait_done("R5 done timeout");
      rd_data(d);
      check(d == 8'(EXP[i]), "R5 result", d, EXP[i]);
      status(s);
      check(s[7] == 0, "R9 read clears flag", s[7], 0);
    end

    // R3 / R4: start and length with divide by 2
    vin = 90;
    wr_ctrl(0, 1, 2);
    status(s);
    check(s == 8'h0A, "R12 status layout", s, 8'h0A);
    check(sample == 0, "R3 no sample before start", sample, 0);
    run_to_end(early, smp);
    check(smp, "R3 sample in first period", smp, 1);
    check(!early, "R4 flag not early", early, 0);
    @(negedge clk);
    status(s);
    check(s[7] == 1, "R4 flag at 12th period", s[7], 1);
    data_peek(d);
    check(d == 90, "R4 result", d, 90);

    // R10: read collides with completion
    vin = 33;
    wr_ctrl(0, 2, 4);
    run_to_end(early, smp);
    addr = 1; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    data_peek(d);
    status(s);
    check(s[7] == 1, "R10 flag kept", s[7], 1);
    check(d == 33, "R10 new result", d, 33);
    rd_data(d);
    status(s);
    check(s[7] == 0, "R9 later read clears", s[7], 0);

    // R11: abort with new channel
    vin = 60;
    wr_ctrl(0, 2, 1);
    repeat (30) @(negedge clk);
    vin = 170;
    wr_ctrl(0, 2, 6);
    check(chan == 3'd6, "R11 chan switch", chan, 6);
    run_to_end(early, smp);
    check(!early, "R11 aborted conversion silent", early, 0);
    @(negedge clk);
    status(s);
    data_peek(d);
    check(s[7] == 1 && d == 170, "R11 restarted result", d, 170);

    // R7: continuous overwrite without reads
    vin = 100;
    wr_ctrl(1, 0, 3);
    wait_done("R7 done timeout");
    data_peek(d);
    check(d == 100, "R7 first result", d, 100);
    status(s);
    check(s[6] == 1, "R12 continuous bit", s[6], 1);
    vin = 200;
    repeat (12) @(negedge clk);
    data_peek(d);
    check(d == 200, "R7 overwrite", d, 200);
    vin = 210;
    repeat (12) @(negedge clk);
    data_peek(d);
    status(s);
    check(d == 210 && s[7], "R7 second overwrite", d, 210);

    // R6: single mode goes idle
    wr_ctrl(0, 0, 3);
    wait_done("R6 done timeout");
    rd_data(d);
    check(d == 210, "R6 single result", d, 210);
    vin = 5;
    repeat (60) @(negedge clk);
    status(s);
    data_peek(d);
    check(s[7] == 0 && d == 210 && !conv_busy, "R6 idle after one", d, 210);

    // R8: control write clears flag
    wr_ctrl(0, 0, 0);
    wait_done("R8 done timeout");
    wr_ctrl(0, 0, 0);
    status(s);
    check(s[7] == 0, "R8 write clears flag", s[7], 0);

    p1 = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule